// File: doc/BRIEF.md
# DDR2 Power-Down Entry and Exit Sequencer

This block sits on the controller side of a DDR2 interface. It owns the clock-enable line of the memory device and decides when to drop it to enter power-down and when to raise it again. An idle request from the scheduler starts an entry attempt. The block then forces the command bus to NOP and waits until no read burst, write burst or mode-register window is still open. It then lowers clock-enable. It picks precharge or active power-down from the open-row flag. For active power-down, a configuration input picks fast or slow exit.

The device leaves power-down when a wake request arrives or when the refresh-interval deadline is reached. In either case the minimum clock-enable hold time must be met first. Once clock-enable is high again, new commands stay gated until the exit latency for the type that was entered has elapsed. All timing parameters are in clock cycles. The command inputs are one-cycle strobes for the commands the scheduler actually issues.

Top module: `ddr2_pd_seq`

## Requirements
- R1: During and right after reset, `cke` is 1, `cmdGate` is 0 and `pdKind` is 0 (none).
- R2: A sampled `idleReq` raises `cmdGate` on the next cycle. `cke` only falls while `cmdGate` is high, so entry happens under NOP. `cmdGate` stays high for the whole time `cke` is low.
- R3: `cke` falls at the first edge that meets all of these: two edges after `idleReq` is sampled; AL+CL+BL/2 edges after a sampled `rdCmd`; AL+CL-1+BL/2 edges after a sampled `wrCmd`; T_MRD edges after a sampled `mrsCmd`.
- R4: At the edge where `cke` falls, `pdKind` takes one of three values, decided by the `anyRowOpen` and `slowExit` inputs sampled at that edge. It is 1 (precharge) when no row is open. It is 2 (active, fast exit) when a row is open and `slowExit` is 0. It is 3 (active, slow exit) when a row is open and `slowExit` is 1. It returns to 0 when `cmdGate` drops after exit.
- R5: After every transition, `cke` holds its new level for at least T_CKE cycles.
- R6: With `wakeReq` sampled while `cke` is low, `cke` rises at the later of the next edge and T_CKE edges after the fall.
- R7: Without a wake request, `cke` rises exactly PD_REFI_MULT*T_REFI edges after it fell, and never later.
- R8: After `cke` rises, `cmdGate` stays high for exactly T_XP cycles (precharge), T_XARD cycles (fast active) or T_XARDS cycles (slow active), then drops.
- R9: If `idleReq` is withdrawn before entry happens, no entry takes place and `cmdGate` drops on the cycle after the withdrawal is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | Level request to enter power-down |
| wakeReq | input | 1 | Level request to leave power-down |
| anyRowOpen | input | 1 | High when any bank has an open row |
| slowExit | input | 1 | Selects slow exit for active power-down |
| rdCmd | input | 1 | A read is issued this cycle |
| wrCmd | input | 1 | A write is issued this cycle |
| mrsCmd | input | 1 | A mode-register write is issued this cycle |
| cke | output | 1 | Clock enable to the memory device |
| cmdGate | output | 1 | High: only NOP may be driven on the command bus |
| pdKind | output | 2 | Power-down type: 0 none, 1 precharge, 2 fast active, 3 slow active |

## Verification
The hardest case to reach from the ports is an entry whose timing is set by a burst window or by the clock-enable hold, not by the idle request. A second hard case is an exit that comes from the refresh deadline rather than a wake. The stimulus reaches the first by issuing a read, write or mode-register command one cycle before the idle request, and by starting a new cycle shortly after the previous exit. It reaches the second by withholding the wake for the whole deadline window. A wake on the very cycle of entry stresses the hold rule on the way out. Random runs mix command kind, row state, exit mode, wake delay and deadline exits, and the bench predicts each edge cycle.

// File: rtl/ddr2_pd_pkg.sv
package ddr2_pd_pkg;

  typedef enum logic [1:0] {
    PD_NONE      = 2'd0,
    PD_PRECHARGE = 2'd1,
    PD_ACT_FAST  = 2'd2,
    PD_ACT_SLOW  = 2'd3
  } pdKind_e;

  typedef enum logic [2:0] {
    ST_ACTIVE     = 3'd0,
    ST_WAIT_SAFE  = 3'd1,
    ST_ENTER_HOLD = 3'd2,
    ST_POWER_DOWN = 3'd3,
    ST_EXIT_HOLD  = 3'd4
  } pdState_e;

  // control -> timer strobes
  typedef struct packed {
    logic ckeEdge;   // cke toggles at this edge
    logic pdStart;   // power-down residency starts
    logic exitLoad;  // load exit latency counter
  } pdStrobe_t;

endpackage

// File: rtl/ddr2_pd_timers.sv
module ddr2_pd_timers
  import ddr2_pd_pkg::*;
#(
  parameter int T_CKE        = 3,
  parameter int T_XP         = 2,
  parameter int T_XARD       = 2,
  parameter int T_XARDS      = 6,
  parameter int T_REFI       = 3120,
  parameter int PD_REFI_MULT = 9,
  parameter int T_MRD        = 2,
  parameter int AL           = 0,
  parameter int CL           = 3,
  parameter int BL           = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdCmd,
  input  logic      wrCmd,
  input  logic      mrsCmd,
  input  pdStrobe_t stb,
  input  pdKind_e   exitKind,
  output logic      blockClear,
  output logic      ckeOk,
  output logic      deadline,
  output logic      exitDone
);
  localparam int NSRC     = 3;
  localparam int RD_BLK   = AL + CL + BL / 2;
  localparam int WR_BLK   = AL + CL - 1 + BL / 2;
  localparam int BLK_A    = (RD_BLK > WR_BLK) ? RD_BLK : WR_BLK;
  localparam int BLK_MAX  = (BLK_A > T_MRD) ? BLK_A : T_MRD;
  localparam int BW       = $clog2(BLK_MAX + 1);
  localparam int AW       = $clog2(T_CKE + 1);
  localparam int PD_LIMIT = PD_REFI_MULT * T_REFI;
  localparam int PW       = $clog2(PD_LIMIT + 1);
  localparam int LAT_A    = (T_XP > T_XARD) ? T_XP : T_XARD;
  localparam int LAT_MAX  = (LAT_A > T_XARDS) ? LAT_A : T_XARDS;
  localparam int LW       = $clog2(LAT_MAX + 1);

  typedef logic [BW-1:0] blk_t;

  // entry-blocking window: one source per command kind
  logic [NSRC-1:0] srcReq;
  blk_t            srcLoad [NSRC];
  blk_t            blkQ, blkNext;

  assign srcReq = {mrsCmd, wrCmd, rdCmd};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int WIN = (s == 0) ? RD_BLK : (s == 1) ? WR_BLK : T_MRD;
    assign srcLoad[s] = srcReq[s] ? blk_t'(WIN - 1) : '0;
  end

  always_comb begin
    blkNext = (blkQ != '0) ? blkQ - 1'b1 : '0;
    for (int s = 0; s < NSRC; s++) begin
      if (srcLoad[s] > blkNext) blkNext = srcLoad[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blkQ <= '0;
    else       blkQ <= blkNext;
  end

  assign blockClear = (blkQ == '0);

  // cycles since the last cke transition, saturating
  logic [AW-1:0] ageQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        ageQ <= AW'(T_CKE - 1);
    else if (stb.ckeEdge)             ageQ <= '0;
    else if (ageQ < AW'(T_CKE - 1))   ageQ <= ageQ + 1'b1;
  end
  assign ckeOk = (ageQ >= AW'(T_CKE - 1));

  // power-down residency against the refresh deadline
  logic [PW-1:0] pdAgeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           pdAgeQ <= '0;
    else if (stb.pdStart)                pdAgeQ <= '0;
    else if (pdAgeQ < PW'(PD_LIMIT - 1)) pdAgeQ <= pdAgeQ + 1'b1;
  end
  assign deadline = (pdAgeQ >= PW'(PD_LIMIT - 1));

  // exit latency, chosen by the type that was entered
  logic [LW-1:0] latLoad, exitQ;
  always_comb begin
    case (exitKind)
      PD_ACT_SLOW: latLoad = LW'(T_XARDS - 1);
      PD_ACT_FAST: latLoad = LW'(T_XARD - 1);
      default:     latLoad = LW'(T_XP - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              exitQ <= '0;
    else if (stb.exitLoad)  exitQ <= latLoad;
    else if (exitQ != '0)   exitQ <= exitQ - 1'b1;
  end
  assign exitDone = (exitQ == '0);

endmodule

// File: rtl/ddr2_pd_ctrl.sv
module ddr2_pd_ctrl
  import ddr2_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      idleReq,
  input  logic      wakeReq,
  input  logic      anyRowOpen,
  input  logic      slowExit,
  input  logic      blockClear,
  input  logic      ckeOk,
  input  logic      deadline,
  input  logic      exitDone,
  output logic      cke,
  output logic      cmdGate,
  output pdKind_e   kind,
  output pdStrobe_t stb
);
  pdState_e stateQ, stateN;
  logic     ckeQ, ckeN;
  pdKind_e  kindQ, kindN;
  logic     inPd, leaveNow;

  assign inPd     = (stateQ == ST_ENTER_HOLD) || (stateQ == ST_POWER_DOWN);
  assign leaveNow = inPd && ckeOk && (wakeReq || deadline);

  always_comb begin
    stateN = stateQ;
    ckeN   = ckeQ;
    kindN  = kindQ;
    stb    = '0;
    case (stateQ)
      ST_ACTIVE: if (idleReq) stateN = ST_WAIT_SAFE;
      ST_WAIT_SAFE: begin
        if (!idleReq) stateN = ST_ACTIVE;
        else if (blockClear && ckeOk) begin
          stateN      = ST_ENTER_HOLD;
          ckeN        = 1'b0;
          stb.ckeEdge = 1'b1;
          stb.pdStart = 1'b1;
          kindN       = !anyRowOpen ? PD_PRECHARGE
                                    : (slowExit ? PD_ACT_SLOW : PD_ACT_FAST);
        end
      end
      ST_ENTER_HOLD: if (ckeOk) stateN = ST_POWER_DOWN;
      ST_POWER_DOWN: ;
      ST_EXIT_HOLD: if (exitDone) begin
        stateN = ST_ACTIVE;
        kindN  = PD_NONE;
      end
      default: stateN = ST_ACTIVE;
    endcase
    if (leaveNow) begin
      stateN       = ST_EXIT_HOLD;
      ckeN         = 1'b1;
      stb.ckeEdge  = 1'b1;
      stb.exitLoad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      ckeQ   <= 1'b1;
      kindQ  <= PD_NONE;
    end else begin
      stateQ <= stateN;
      ckeQ   <= ckeN;
      kindQ  <= kindN;
    end
  end

  assign cke     = ckeQ;
  assign cmdGate = (stateQ != ST_ACTIVE);
  assign kind    = kindQ;

endmodule

// File: rtl/ddr2_pd_seq.sv
module ddr2_pd_seq
  import ddr2_pd_pkg::*;
#(
  parameter int T_CKE        = 3,
  parameter int T_XP         = 2,
  parameter int T_XARD       = 2,
  parameter int T_XARDS      = 6,
  parameter int T_REFI       = 3120,
  parameter int PD_REFI_MULT = 9,
  parameter int T_MRD        = 2,
  parameter int AL           = 0,
  parameter int CL           = 3,
  parameter int BL           = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       wakeReq,
  input  logic       anyRowOpen,
  input  logic       slowExit,
  input  logic       rdCmd,
  input  logic       wrCmd,
  input  logic       mrsCmd,
  output logic       cke,
  output logic       cmdGate,
  output logic [1:0] pdKind
);
  pdStrobe_t stb;
  pdKind_e   kind;
  logic      blockClear, ckeOk, deadline, exitDone;

  ddr2_pd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .wakeReq(wakeReq),
    .anyRowOpen(anyRowOpen), .slowExit(slowExit), .blockClear(blockClear),
    .ckeOk(ckeOk), .deadline(deadline), .exitDone(exitDone),
    .cke(cke), .cmdGate(cmdGate), .kind(kind), .stb(stb)
  );

  ddr2_pd_timers #(
    .T_CKE(T_CKE), .T_XP(T_XP), .T_XARD(T_XARD), .T_XARDS(T_XARDS),
    .T_REFI(T_REFI), .PD_REFI_MULT(PD_REFI_MULT), .T_MRD(T_MRD),
    .AL(AL), .CL(CL), .BL(BL)
  ) timers_i (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .wrCmd(wrCmd), .mrsCmd(mrsCmd),
    .stb(stb), .exitKind(kind), .blockClear(blockClear), .ckeOk(ckeOk),
    .deadline(deadline), .exitDone(exitDone)
  );

  assign pdKind = kind;

endmodule

// File: rtl/ddr2_pd_seq_chk.sv
module ddr2_pd_seq_chk #(
  parameter int T_CKE    = 3,
  parameter int PD_LIMIT = 144,
  parameter int RD_BLK   = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic       cmdGate,
  input logic       anyRowOpen,
  input logic       slowExit,
  input logic       rdCmd,
  input logic [1:0] pdKind
);
  localparam int RW = $clog2(T_CKE + 1);
  localparam int LW = $clog2(PD_LIMIT + 2);
  localparam int DW = $clog2(RD_BLK + 1);

  logic          ckePrevQ;
  logic [RW-1:0] runQ;
  logic [LW-1:0] lowRunQ;
  logic [DW-1:0] rdAgeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrevQ <= 1'b1;
      runQ     <= RW'(T_CKE);
      lowRunQ  <= '0;
      rdAgeQ   <= DW'(RD_BLK);
    end else begin
      ckePrevQ <= cke;
      if (cke != ckePrevQ)          runQ <= RW'(1);
      else if (runQ < RW'(T_CKE))   runQ <= runQ + 1'b1;
      if (cke)                                lowRunQ <= '0;
      else if (lowRunQ < LW'(PD_LIMIT + 1))   lowRunQ <= lowRunQ + 1'b1;
      if (rdCmd)                      rdAgeQ <= '0;
      else if (rdAgeQ < DW'(RD_BLK))  rdAgeQ <= rdAgeQ + 1'b1;
    end
  end

  // R5
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cke != ckePrevQ) |-> (runQ >= RW'(T_CKE)));

  // R7
  pd_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowRunQ <= LW'(PD_LIMIT));

  // R2
  entry_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> $past(cmdGate));

  // R2
  low_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> cmdGate);

  // R4
  pd_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (pdKind == (!$past(anyRowOpen) ? 2'd1 :
                              ($past(slowExit) ? 2'd3 : 2'd2))));

  // R3
  rd_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (rdAgeQ >= DW'(RD_BLK)));

  // R8
  exit_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (cmdGate && pdKind != 2'd0));

endmodule

bind ddr2_pd_seq ddr2_pd_seq_chk #(
  .T_CKE(T_CKE), .PD_LIMIT(PD_REFI_MULT * T_REFI), .RD_BLK(AL + CL + BL / 2)
) chk_i (
  .clk(clk), .rstN(rstN), .cke(cke), .cmdGate(cmdGate),
  .anyRowOpen(anyRowOpen), .slowExit(slowExit), .rdCmd(rdCmd), .pdKind(pdKind)
);

// File: tb/ddr2_pd_seq_tb_top.sv
module ddr2_pd_seq_tb_top;
  localparam int T_CKE = 3, T_XP = 2, T_XARD = 2, T_XARDS = 6;
  localparam int T_REFI = 16, MULT = 9, T_MRD = 2, AL = 0, CL = 3, BL = 4;
  localparam int LIMIT = MULT * T_REFI;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, idleReq, wakeReq, anyRowOpen, slowExit, rdCmd, wrCmd, mrsCmd;
  logic cke, cmdGate;
  logic [1:0] pdKind;

  ddr2_pd_seq #(
    .T_CKE(T_CKE), .T_XP(T_XP), .T_XARD(T_XARD), .T_XARDS(T_XARDS),
    .T_REFI(T_REFI), .PD_REFI_MULT(MULT), .T_MRD(T_MRD), .AL(AL), .CL(CL), .BL(BL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .wakeReq(wakeReq),
    .anyRowOpen(anyRowOpen), .slowExit(slowExit), .rdCmd(rdCmd), .wrCmd(wrCmd),
    .mrsCmd(mrsCmd), .cke(cke), .cmdGate(cmdGate), .pdKind(pdKind)
  );

  int checks = 0, errors = 0, cyc = 0, lastRise = -100;

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // kind: 0 none, 1 read, 2 write, 3 mode register
  function automatic int blockWin(int kind);
    case (kind)
      1: return AL + CL + BL / 2;
      2: return AL + CL - 1 + BL / 2;
      3: return T_MRD;
      default: return 0;
    endcase
  endfunction

  function automatic int expKind(bit row, bit slow);
    return !row ? 1 : (slow ? 3 : 2);
  endfunction

  function automatic int exitLat(int k);
    return (k == 3) ? T_XARDS : (k == 2) ? T_XARD : T_XP;
  endfunction

  task automatic scenario(int kind, bit row, bit slow, bit wake, int wdly);
    int t0, expF, expR, fallC, riseC, gateC, w, k;
    t0 = cyc;
    rdCmd  = (kind == 1);
    wrCmd  = (kind == 2);
    mrsCmd = (kind == 3);
    tick();
    rdCmd = 0; wrCmd = 0; mrsCmd = 0;
    idleReq = 1; anyRowOpen = row; slowExit = slow;
    tick();
    check("R2", cmdGate, 1, "gate one cycle after idle request");
    expF = maxi(maxi(t0 + 3, t0 + 1 + blockWin(kind)), lastRise + T_CKE);
    for (int i = 0; i < 60 && cke !== 1'b0; i++) tick();
    fallC = cyc;
    check("R3", fallC, expF, "cke fall cycle");
    k = expKind(row, slow);
    check("R4", pdKind, k, "type at entry");
    idleReq = 0;
    if (wake) begin
      for (int i = 0; i < wdly; i++) tick();
      w = cyc;
      wakeReq = 1;
      expR = maxi(w + 1, fallC + T_CKE);
    end else begin
      expR = fallC + LIMIT;
    end
    for (int i = 0; i < LIMIT + 20 && cke !== 1'b1; i++) begin
      tick();
      if (cmdGate !== 1'b1) check("R2", cmdGate, 1, "gate while cke low");
    end
    riseC = cyc;
    check(wake ? "R6" : "R7", riseC, expR, "cke rise cycle");
    check("R5", int'(riseC - fallC >= T_CKE), 1, "low hold length");
    wakeReq = 0;
    check("R8", cmdGate, 1, "gate at rise");
    for (int i = 0; i < 30 && cmdGate !== 1'b0; i++) tick();
    gateC = cyc;
    check("R8", gateC - riseC, exitLat(k), "exit gate length");
    check("R4", pdKind, 0, "type cleared after exit");
    lastRise = riseC;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    rstN = 0; idleReq = 0; wakeReq = 0; anyRowOpen = 0; slowExit = 0;
    rdCmd = 0; wrCmd = 0; mrsCmd = 0;
    tick(); tick(); tick();
    check("R1", cke, 1, "cke in reset");
    check("R1", cmdGate, 0, "gate in reset");
    check("R1", pdKind, 0, "type in reset");
    rstN = 1;
    tick(); tick();
    check("R1", cke, 1, "cke after reset");
    check("R1", cmdGate, 0, "gate after reset");

    // directed corners
    scenario(1, 0, 0, 1, 0);   // read window, wake at entry cycle
    scenario(2, 1, 0, 1, 3);   // write window, fast active
    scenario(3, 1, 1, 1, 5);   // mode register, slow active
    scenario(0, 1, 1, 0, 0);   // deadline exit, slow active
    scenario(0, 0, 0, 0, 0);   // deadline exit, precharge
    scenario(1, 1, 0, 1, 1);   // back-to-back: hold from previous rise

    // R9: idle withdrawn while a read window blocks entry
    rdCmd = 1;
    tick();
    rdCmd = 0; idleReq = 1;
    tick();
    check("R9", cmdGate, 1, "gate raised before withdrawal");
    idleReq = 0;
    tick();
    check("R9", cmdGate, 0, "gate dropped after withdrawal");
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (cke !== 1'b1) lows++;
    end
    check("R9", lows, 0, "no entry after withdrawal");

    // random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 40; n++) begin
      int kind, gap, dly;
      bit row, slow, wake;
      kind = int'($urandom % 4);
      row  = 1'($urandom % 2);
      slow = 1'($urandom % 2);
      wake = (($urandom % 5) != 0);
      dly  = int'($urandom % 9);
      gap  = int'($urandom % 4);
      for (int g = 0; g < gap; g++) tick();
      scenario(kind, row, slow, wake, dly);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule